// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight ownership flags that two independent ports, left and right, use to agree on which of them may touch a shared resource. The flags are separate from any memory array. A port selects the bank with its own active-low semaphore select while its memory enable stays inactive. It picks one of the eight flags with the low address bits. It asks for a flag by writing zero, gives it up by writing one, and reads the flag back to learn the outcome.

Each flag records a pending request per side plus which side won. A request from the side that does not own the flag is held. When the owner releases, that held request takes over at once, with no retry. Same-cycle requests for a free flag go to the left port. A read captures the flag into a per-port register and drives it on every data bit. That value holds until the same port reads again.

Top module: `semaphore_bank`

## Requirements
- R1: After reset all eight flags are free with no request pending, and both read data buses are all ones.
- R2: A port takes part in a flag operation only in a cycle where its semaphore select is low and its memory enable input is high. A read also needs output enable low and read/write high. Any other cycle changes no flag and leaves that port's read data unchanged.
- R3: The flag index is address bits [2:0]. All higher address bits have no effect.
- R4: A write uses only data bit 0: 0 asks for the flag, 1 releases it or withdraws a pending request. Higher data bits have no effect.
- R5: When one side asks for a free flag, that side then reads 0 and the other side reads 1.
- R6: While a side owns a flag, no write from the other side changes the owner.
- R7: If the non-owner asked while the flag was owned, the non-owner becomes owner in the cycle after the owner's release write.
- R8: Once both sides have released a flag, both sides read 1 from it.
- R9: A release write from the non-owner withdraws its pending request, so a later release by the owner leaves the flag free.
- R10: When both sides ask for the same free flag in the same cycle, the left side becomes owner.
- R11: A read drives the flag value on every bit of that port's read data: all zeros means owned by the reader, all ones means not owned.
- R12: A read captures the flag state from before that clock edge's writes into a per-port register. The value holds until that port's next read, whatever the other port writes.
- R13: An operation on one flag leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| semSelLN | input | 1 | Left semaphore select, active low |
| memEnLN | input | 1 | Left memory enable, active low; must be high for flag access |
| rwLN | input | 1 | Left read (1) / write (0) |
| oeLN | input | 1 | Left output enable, active low |
| addrL | input | ADDR_W | Left address; bits [2:0] choose the flag |
| wrDataL | input | DATA_W | Left write data; bit 0 used |
| rdDataL | output | DATA_W | Left captured read data |
| semSelRN | input | 1 | Right semaphore select, active low |
| memEnRN | input | 1 | Right memory enable, active low; must be high for flag access |
| rwRN | input | 1 | Right read (1) / write (0) |
| oeRN | input | 1 | Right output enable, active low |
| addrR | input | ADDR_W | Right address; bits [2:0] choose the flag |
| wrDataR | input | DATA_W | Right write data; bit 0 used |
| rdDataR | output | DATA_W | Right captured read data |

## Verification
On every cycle the assertions check four things. An owner keeps a flag until it releases. A held request takes over on the release. A same-cycle tie on a free flag goes left. Flag state and read registers stay still when no strobe asks them to move. Only the directed scenarios can show what each port actually sees: the gating by select and enable, the address and data bits that are ignored, the withdrawal of a held request, and the capture of pre-write state when one port reads while the other writes.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  localparam int NUM_SEM   = 8;
  localparam int SEM_IDX_W = $clog2(NUM_SEM);

  typedef struct packed {
    logic                 wrReq;
    logic                 wrRel;
    logic                 rd;
    logic [SEM_IDX_W-1:0] idx;
  } semStrobeT;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import sem_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              semSelN,
  input  logic              memEnN,
  input  logic              rwN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output semStrobeT         strobe
);
  logic access;
  logic unusedBits;

  // flag space is entered only with the memory side idle
  assign access = ~semSelN & memEnN;

  always_comb begin
    strobe.wrReq = access & ~rwN & ~wrData[0];
    strobe.wrRel = access & ~rwN &  wrData[0];
    strobe.rd    = access &  rwN & ~oeN;
    strobe.idx   = addr[SEM_IDX_W-1:0];
  end

  assign unusedBits = ^{addr[ADDR_W-1:SEM_IDX_W], wrData[DATA_W-1:1]};
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import sem_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  semStrobeT         strobeL,
  input  semStrobeT         strobeR,
  output logic [DATA_W-1:0] rdDataL,
  output logic [DATA_W-1:0] rdDataR
);
  logic [NUM_SEM-1:0] reqL, reqR, ownerLeft;
  logic [NUM_SEM-1:0] ownL, ownR;
  logic               rdBitL, rdBitR;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic hitL, hitR, wReqL, wRelL, wReqR, wRelR;
    logic nextReqL, nextReqR, nextOwnerLeft;

    assign hitL  = (strobeL.idx == SEM_IDX_W'(i));
    assign hitR  = (strobeR.idx == SEM_IDX_W'(i));
    assign wReqL = strobeL.wrReq & hitL;
    assign wRelL = strobeL.wrRel & hitL;
    assign wReqR = strobeR.wrReq & hitR;
    assign wRelR = strobeR.wrRel & hitR;

    assign nextReqL = (reqL[i] | wReqL) & ~wRelL;
    assign nextReqR = (reqR[i] | wReqR) & ~wRelR;

    // owner bit only matters while both sides hold a request
    always_comb begin
      if (reqL[i] && reqR[i])  nextOwnerLeft = ownerLeft[i];
      else if (reqL[i])        nextOwnerLeft = 1'b1;
      else if (reqR[i])        nextOwnerLeft = 1'b0;
      else                     nextOwnerLeft = 1'b1; // tie on a free flag
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqL[i]      <= 1'b0;
        reqR[i]      <= 1'b0;
        ownerLeft[i] <= 1'b1;
      end else begin
        reqL[i]      <= nextReqL;
        reqR[i]      <= nextReqR;
        ownerLeft[i] <= nextOwnerLeft;
      end
    end

    assign ownL[i] = reqL[i] & (~reqR[i] |  ownerLeft[i]);
    assign ownR[i] = reqR[i] & (~reqL[i] | ~ownerLeft[i]);

    a_r6_left_keeps: assert property (@(posedge clk) disable iff (!rstN)
      ownL[i] && !wRelL |=> ownL[i]);
    a_r6_right_keeps: assert property (@(posedge clk) disable iff (!rstN)
      ownR[i] && !wRelR |=> ownR[i]);
    a_r7_handover_to_right: assert property (@(posedge clk) disable iff (!rstN)
      ownL[i] && reqR[i] && wRelL && !wRelR |=> ownR[i]);
    a_r7_handover_to_left: assert property (@(posedge clk) disable iff (!rstN)
      ownR[i] && reqL[i] && wRelR && !wRelL |=> ownL[i]);
    a_r10_tie_left: assert property (@(posedge clk) disable iff (!rstN)
      !reqL[i] && !reqR[i] && wReqL && wReqR |=> ownL[i] && !ownR[i]);
  end

  // read captures state before this edge's writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBitL <= 1'b1;
      rdBitR <= 1'b1;
    end else begin
      if (strobeL.rd) rdBitL <= ~ownL[strobeL.idx];
      if (strobeR.rd) rdBitR <= ~ownR[strobeR.idx];
    end
  end

  assign rdDataL = {DATA_W{rdBitL}};
  assign rdDataR = {DATA_W{rdBitR}};

  a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(strobeL.wrReq || strobeL.wrRel || strobeR.wrReq || strobeR.wrRel)
    |=> $stable(reqL) && $stable(reqR));
  a_r12_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobeL.rd |=> $stable(rdDataL));
  a_r12_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobeR.rd |=> $stable(rdDataR));
endmodule

// File: rtl/semaphore_bank.sv
module semaphore_bank
  import sem_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              semSelLN,
  input  logic              memEnLN,
  input  logic              rwLN,
  input  logic              oeLN,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wrDataL,
  output logic [DATA_W-1:0] rdDataL,
  input  logic              semSelRN,
  input  logic              memEnRN,
  input  logic              rwRN,
  input  logic              oeRN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataR,
  output logic [DATA_W-1:0] rdDataR
);
  semStrobeT strobeL, strobeR;

  semCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrlL (
    .semSelN(semSelLN), .memEnN(memEnLN), .rwN(rwLN), .oeN(oeLN),
    .addr(addrL), .wrData(wrDataL), .strobe(strobeL)
  );

  semCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrlR (
    .semSelN(semSelRN), .memEnN(memEnRN), .rwN(rwRN), .oeN(oeRN),
    .addr(addrR), .wrData(wrDataR), .strobe(strobeR)
  );

  semDatapath #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobeL(strobeL), .strobeR(strobeR),
    .rdDataL(rdDataL), .rdDataR(rdDataR)
  );
endmodule

// File: tb/semaphore_bank_tb.sv
`timescale 1ns/1ps
module semaphore_bank_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic semSelLN, memEnLN, rwLN, oeLN, semSelRN, memEnRN, rwRN, oeRN;
  logic [ADDR_W-1:0] addrL, addrR;
  logic [DATA_W-1:0] wrDataL, wrDataR, rdDataL, rdDataR;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  semaphore_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .semSelLN(semSelLN), .memEnLN(memEnLN), .rwLN(rwLN), .oeLN(oeLN),
    .addrL(addrL), .wrDataL(wrDataL), .rdDataL(rdDataL),
    .semSelRN(semSelRN), .memEnRN(memEnRN), .rwRN(rwRN), .oeRN(oeRN),
    .addrR(addrR), .wrDataR(wrDataR), .rdDataR(rdDataR)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idleAll();
    semSelLN = 1; memEnLN = 1; rwLN = 1; oeLN = 1; addrL = '0; wrDataL = '0;
    semSelRN = 1; memEnRN = 1; rwRN = 1; oeRN = 1; addrR = '0; wrDataR = '0;
  endtask

  // set one side for a write (called at a negedge)
  task automatic setWr(input bit left, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
    if (left) begin semSelLN = 0; memEnLN = 1; rwLN = 0; oeLN = 1; addrL = a; wrDataL = d; end
    else      begin semSelRN = 0; memEnRN = 1; rwRN = 0; oeRN = 1; addrR = a; wrDataR = d; end
  endtask

  task automatic setRd(input bit left, input logic [ADDR_W-1:0] a);
    if (left) begin semSelLN = 0; memEnLN = 1; rwLN = 1; oeLN = 0; addrL = a; end
    else      begin semSelRN = 0; memEnRN = 1; rwRN = 1; oeRN = 0; addrR = a; end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idleAll();
  endtask

  task automatic wr(input bit left, input logic [ADDR_W-1:0] a, input bit b);
    setWr(left, a, {{(DATA_W-1){1'b0}}, b});
    step();
  endtask

  // read and check value on every bit (R11)
  task automatic rdChk(input string tag, input bit left,
                       input logic [ADDR_W-1:0] a, input bit expBit);
    setRd(left, a);
    step();
    check(tag, left ? rdDataL : rdDataR, {DATA_W{expBit}});
  endtask

  task automatic t_reset();
    check("R1 left bus after reset", rdDataL, '1);
    check("R1 right bus after reset", rdDataR, '1);
    for (int i = 0; i < 8; i++) begin
      rdChk("R1 left flag free", 1, ADDR_W'(i), 1'b1);
      rdChk("R1 right flag free", 0, ADDR_W'(i), 1'b1);
    end
  endtask

  task automatic t_request();
    setWr(1, 16'h0002, 16'hFFFE); step();          // bit0=0, upper ones ignored (R4)
    rdChk("R5 R11 left owns flag2", 1, 16'h0002, 1'b0);
    rdChk("R5 right sees flag2 taken", 0, 16'h0002, 1'b1);
    setWr(1, 16'h0002, 16'h0001); step();          // release
    rdChk("R4 R8 left released flag2", 1, 16'h0002, 1'b1);
    rdChk("R8 right sees flag2 free", 0, 16'h0002, 1'b1);
  endtask

  task automatic t_queue();
    wr(1, 16'h0002, 1'b0);
    wr(0, 16'h0002, 1'b0);                         // right queues
    rdChk("R6 left still owns", 1, 16'h0002, 1'b0);
    rdChk("R6 right still waiting", 0, 16'h0002, 1'b1);
    wr(1, 16'h0002, 1'b1);                         // left releases
    rdChk("R7 right takes over", 0, 16'h0002, 1'b0);
    rdChk("R7 left lost flag", 1, 16'h0002, 1'b1);
    wr(0, 16'h0002, 1'b1);
    rdChk("R8 both free left", 1, 16'h0002, 1'b1);
    rdChk("R8 both free right", 0, 16'h0002, 1'b1);
  endtask

  task automatic t_cancel();
    wr(1, 16'h0003, 1'b0);
    wr(0, 16'h0003, 1'b0);
    wr(0, 16'h0003, 1'b1);                         // right withdraws
    rdChk("R6 owner after withdraw", 1, 16'h0003, 1'b0);
    wr(1, 16'h0003, 1'b1);
    rdChk("R9 right not granted", 0, 16'h0003, 1'b1);
    rdChk("R9 left free", 1, 16'h0003, 1'b1);
  endtask

  task automatic t_tie();
    setWr(1, 16'h0005, '0);
    setWr(0, 16'h0005, '0);
    step();
    rdChk("R10 left wins tie", 1, 16'h0005, 1'b0);
    rdChk("R10 right loses tie", 0, 16'h0005, 1'b1);
    wr(1, 16'h0005, 1'b1);
    rdChk("R10 R7 right gets after tie", 0, 16'h0005, 1'b0);
    wr(0, 16'h0005, 1'b1);
  endtask

  task automatic t_addr();
    wr(1, 16'hABC6, 1'b0);
    rdChk("R3 right sees flag6 low addr", 0, 16'h0006, 1'b1);
    rdChk("R3 left owns flag6 other high bits", 1, 16'h5556, 1'b0);
    rdChk("R13 flag7 untouched", 0, 16'h0007, 1'b1);
    rdChk("R13 flag4 untouched", 1, 16'h0004, 1'b1);
  endtask

  task automatic t_gate();
    // memory enable low: no flag write
    setWr(1, 16'h0001, '0); memEnLN = 0; step();
    rdChk("R2 memEn low write ignored", 0, 16'h0001, 1'b1);
    // select high: no flag write
    setWr(1, 16'h0001, '0); semSelLN = 1; step();
    rdChk("R2 select high write ignored", 1, 16'h0001, 1'b1);
    // left holds flag6 from t_addr: capture 0 then attempt reads that must not update
    rdChk("R2 left capture flag6", 1, 16'h0006, 1'b0);
    setRd(1, 16'h0007); oeLN = 1; step();
    check("R2 oe high read ignored", rdDataL, '0);
    setRd(1, 16'h0007); memEnLN = 0; step();
    check("R2 memEn low read ignored", rdDataL, '0);
    wr(1, 16'h0006, 1'b1);
  endtask

  task automatic t_latch();
    rdChk("R12 left capture flag0", 1, 16'h0000, 1'b1);
    wr(1, 16'h0000, 1'b0);
    check("R12 held after own write", rdDataL, '1);
    wr(0, 16'h0000, 1'b0);
    wr(0, 16'h0000, 1'b1);
    check("R12 held across other port writes", rdDataL, '1);
    rdChk("R12 new read updates", 1, 16'h0000, 1'b0);
    wr(1, 16'h0000, 1'b1);
    // same-edge read by left and request by right: pre-write state captured
    setRd(1, 16'h0004);
    setWr(0, 16'h0004, '0);
    step();
    check("R12 read sees pre-write state", rdDataL, '1);
    rdChk("R12 right write still landed", 0, 16'h0004, 1'b0);
    wr(0, 16'h0004, 1'b1);
  endtask

  initial begin
    idleAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_request();
    t_queue();
    t_cancel();
    t_tie();
    t_addr();
    t_gate();
    t_latch();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule